// File: doc/BRIEF.md
# Inversion-Inserted Secure Scan Register

This block is a drop-in replacement for a plain k-stage scan chain segment. Between selected stages, and in front of the first stage, fixed inverters sit on the shift path, so the values held in the flip-flops are a scrambled form of the values the chain logically carries. The inverters are placed at elaboration time through a mask parameter. Their count must be even, and the block refuses to elaborate otherwise. With an even count, the serial path from scan input to scan output behaves exactly like an ordinary shift register, so a tester needs no knowledge of the inverter layout. The kernel-facing parallel outputs undo the stored inversion and present each stage's true logical value. The parallel capture path re-encodes the kernel's data before it is stored.

A synchronous reset clears every flip-flop. Because the inverters are hidden, an all-zero physical state corresponds to a logical pattern that maps the inverter layout exactly. The block therefore carries a control flip-flop. Reset sets it, and the first capture that actually takes effect clears it. While it is set, the scan output is held at 0, so shifting out straight after reset exposes nothing.

Top module: `inv_scan_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every stage is cleared. After that edge `par_out` bit i equals the parity of `INV_MASK` bits 0..i, which is 8'h27 for the default mask 8'b0110_1001, and `scan_out` is 0.
- R2: From a reset edge until the first capture that takes effect, `scan_out` stays 0 whatever the chain holds or shifts.
- R3: With `capture` high and `scan_en` low, `par_out` equals the sampled `par_in` after the edge, and the scan-out lock is released.
- R4: With `scan_en` high, each edge moves `par_out[i-1]` into `par_out[i]` and `scan_in` into `par_out[0]`, exactly as in a plain shift register.
- R5: Once unlocked, `scan_out` equals `par_out[STAGES-1]`. Any pattern shifted in through `scan_in` leaves `scan_out` in the same bit order after `STAGES` further shifts.
- R6: When `scan_en` and `capture` are both high, the edge shifts, `par_in` has no effect, and the lock keeps its state.
- R7: `rst` overrides both `scan_en` and `capture`.
- R8: With `rst`, `scan_en` and `capture` all low, `par_out` and `scan_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Serial shift enable, takes priority over capture |
| capture | input | 1 | Parallel load from the kernel |
| scan_in | input | 1 | Serial data into the first stage |
| par_in | input | STAGES | Kernel data captured into the stages |
| par_out | output | STAGES | True logical value of each stage, sent to the kernel |
| scan_out | output | 1 | Serial data from the last stage, forced to 0 while locked |

## Verification
The hardest state to reach is a locked chain that holds a logical 1 in its last stage. A 1 has to exist at the scan tap while the lock is still set; only then is the forced 0 observable rather than coincidental. The stimulus resets the block, which leaves the polarity pattern in the chain, and then shifts ones in until a 1 reaches the top stage. Along the way it raises `scan_en` and `capture` together, to show that a capture which loses to a shift does not release the lock.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // widest chain the polarity helper supports
  parameter int MAX_STAGES = 256;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ssr_op_e;

  // bit i of the result = XOR of mask bits 0..i (stored polarity of stage i)
  function automatic logic [MAX_STAGES-1:0] prefix_parity(input logic [MAX_STAGES-1:0] mask);
    logic [MAX_STAGES-1:0] acc;
    logic run;
    run = 1'b0;
    for (int i = 0; i < MAX_STAGES; i++) begin
      run    = run ^ mask[i];
      acc[i] = run;
    end
    return acc;
  endfunction

endpackage

// File: rtl/ssr_stage.sv
module ssr_stage
  import ssr_pkg::*;
#(
  parameter logic INV_IN = 1'b0,  // inverter on the shift path into this stage
  parameter logic POL    = 1'b0   // stored polarity of this stage
) (
  input  logic    clk,
  input  ssr_op_e op,
  input  logic    shift_d,        // stored value of the previous stage or scan input
  input  logic    load_d,         // true value from the kernel
  output logic    q_raw,
  output logic    q_true
);

  logic q;

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= 1'b0;
      OP_SHIFT: q <= shift_d ^ INV_IN;
      OP_LOAD:  q <= load_d ^ POL;
      default:  q <= q;
    endcase
  end

  assign q_raw  = q;
  assign q_true = q ^ POL;

endmodule

// File: rtl/ssr_guard.sv
module ssr_guard
  import ssr_pkg::*;
(
  input  logic    clk,
  input  ssr_op_e op,
  input  logic    tap,      // stored value of the last stage
  output logic    locked,
  output logic    scan_out
);

  always_ff @(posedge clk) begin
    if (op == OP_CLEAR)     locked <= 1'b1;
    else if (op == OP_LOAD) locked <= 1'b0;
  end

  assign scan_out = tap & ~locked;

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic    rst,
  input  logic    scan_en,
  input  logic    capture,
  output ssr_op_e op
);

  always_comb begin
    if (rst)          op = OP_CLEAR;
    else if (scan_en) op = OP_SHIFT;
    else if (capture) op = OP_LOAD;
    else              op = OP_HOLD;
  end

endmodule

// File: rtl/inv_scan_reg.sv
module inv_scan_reg
  import ssr_pkg::*;
#(
  parameter int                STAGES   = 8,
  parameter logic [STAGES-1:0] INV_MASK = 8'b0110_1001  // bit i: inverter in front of stage i
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_en,
  input  logic              capture,
  input  logic              scan_in,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] par_out,
  output logic              scan_out
);

  localparam logic [MAX_STAGES-1:0] WIDE_MASK = MAX_STAGES'(INV_MASK);
  localparam logic [STAGES-1:0]     POL_MAP   = STAGES'(prefix_parity(WIDE_MASK));
  localparam int                    INV_COUNT = $countones(INV_MASK);

  generate
    if (STAGES < 2 || STAGES > MAX_STAGES) begin : g_bad_len
      $error("inv_scan_reg: STAGES out of range");
    end
    if ((INV_COUNT % 2) != 0) begin : g_odd_inv
      $error("inv_scan_reg: inverter count must be even");
    end
  endgenerate

  ssr_op_e           op;
  logic [STAGES-1:0] raw;
  logic              locked;

  ssr_ctrl u_ctrl (
    .rst     (rst),
    .scan_en (scan_en),
    .capture (capture),
    .op      (op)
  );

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic sd;
      if (i == 0) begin : g_head
        assign sd = scan_in;
      end else begin : g_body
        assign sd = raw[i-1];
      end
      ssr_stage #(
        .INV_IN (INV_MASK[i]),
        .POL    (POL_MAP[i])
      ) u_stage (
        .clk     (clk),
        .op      (op),
        .shift_d (sd),
        .load_d  (par_in[i]),
        .q_raw   (raw[i]),
        .q_true  (par_out[i])
      );
    end
  endgenerate

  // even inverter count: last stage polarity is zero, tap needs no correction
  ssr_guard u_guard (
    .clk      (clk),
    .op       (op),
    .tap      (raw[STAGES-1]),
    .locked   (locked),
    .scan_out (scan_out)
  );

endmodule

// File: rtl/inv_scan_reg_chk.sv
module inv_scan_reg_chk
  import ssr_pkg::*;
#(
  parameter int                STAGES   = 8,
  parameter logic [STAGES-1:0] INV_MASK = 8'b0110_1001
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_en,
  input logic              capture,
  input logic              scan_in,
  input logic [STAGES-1:0] par_in,
  input logic [STAGES-1:0] par_out,
  input logic              scan_out,
  input logic              locked
);

  localparam logic [STAGES-1:0] EXP_RST = STAGES'(prefix_parity(MAX_STAGES'(INV_MASK)));

  // R1
  reset_pattern_chk: assert property (@(posedge clk)
    rst |=> (par_out == EXP_RST) && (scan_out == 1'b0));

  // R2
  locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (scan_out == 1'b0));

  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && !scan_en) |=> (par_out == $past(par_in)) && !locked);

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> par_out == {$past(par_out[STAGES-2:0]), $past(scan_in)});

  // R5
  tap_value_chk: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (scan_out == par_out[STAGES-1]));

  // R6
  shift_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_en && capture) |=> $stable(locked));

  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !capture) |=> $stable(par_out) && $stable(scan_out));

endmodule

bind inv_scan_reg inv_scan_reg_chk #(
  .STAGES   (STAGES),
  .INV_MASK (INV_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scan_en  (scan_en),
  .capture  (capture),
  .scan_in  (scan_in),
  .par_in   (par_in),
  .par_out  (par_out),
  .scan_out (scan_out),
  .locked   (locked)
);

// File: tb/tb_inv_scan_reg.sv
module tb_inv_scan_reg;

  localparam int           K    = 8;
  localparam logic [K-1:0] MASK = 8'b0110_1001;

  logic         clk = 1'b0;
  logic         rst, scan_en, capture, scan_in;
  logic [K-1:0] par_in, par_out;
  logic         scan_out;

  always #4 clk = ~clk;  // 125 MHz

  inv_scan_reg #(.STAGES(K), .INV_MASK(MASK)) dut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .capture(capture),
    .scan_in(scan_in), .par_in(par_in), .par_out(par_out), .scan_out(scan_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {req[4], rst, scan_en, capture, scan_in, par_in[8], exp_par_out[8], exp_scan_out}
  localparam int VW = 25;
  localparam int NV = 15;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h27, 1'b0},  // R1 reset pattern
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5, 1'b1},  // R3 capture unlocks
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hA5, 1'b1},  // R8 hold
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h4A, 1'b0},  // R4 shift 0
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h95, 1'b1},  // R4 shift 1
    {4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h2A, 1'b0},  // R6 shift wins
    {4'd7, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h27, 1'b0},  // R7 reset wins
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h4F, 1'b0},  // R2 locked shift
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h9F, 1'b0},  // R2 top is 1, tap quiet
    {4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3E, 1'b0},  // R6 lock kept
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h7C, 1'b0},  // R2
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hF8, 1'b0},  // R2 still locked
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b0},  // R3
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, 8'hC3, 1'b1},  // R3
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 1'b1}   // R8
  };

  task automatic shift_bit(input logic b);
    @(negedge clk);
    rst = 1'b0; scan_en = 1'b1; capture = 1'b0; scan_in = b;
    @(posedge clk);
    #2;
  endtask

  localparam logic [K-1:0] PATS [3] = '{8'hB4, 8'h01, 8'hE7};

  initial begin
    rst = 1'b1; scan_en = 1'b0; capture = 1'b0; scan_in = 1'b0; par_in = '0;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst     = VEC[i][20];
      scan_en = VEC[i][19];
      capture = VEC[i][18];
      scan_in = VEC[i][17];
      par_in  = VEC[i][16:9];
      @(posedge clk);
      #2;
      check($sformatf("R%0d vec%0d par_out", VEC[i][24:21], i), 32'(par_out), 32'(VEC[i][8:1]));
      check($sformatf("R%0d vec%0d scan_out", VEC[i][24:21], i), 32'(scan_out), 32'(VEC[i][0]));
    end

    // R5: end-to-end serial transparency against a reference shift register
    @(negedge clk);
    rst = 1'b0; scan_en = 1'b0; capture = 1'b1; par_in = '0;
    @(posedge clk);
    for (int p = 0; p < 3; p++) begin
      logic [K-1:0] ref_sr;
      ref_sr = '0;
      for (int j = 0; j < K; j++) begin
        shift_bit(PATS[p][j]);
        ref_sr = {ref_sr[K-2:0], PATS[p][j]};
      end
      check("R4 reference shift", 32'(par_out), 32'(ref_sr));
      for (int j = 0; j < K; j++) begin
        check($sformatf("R5 pattern%0d bit%0d", p, j), 32'(scan_out), 32'(PATS[p][j]));
        shift_bit(1'b0);
      end
    end

    @(negedge clk);
    scan_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule